// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between on-chip logic running on a single system clock and an external asynchronous static RAM of 128K bytes. The RAM has 17 address lines, an 8-bit data bus, a pair of chip enables (one active low, one active high), an active-low output enable and an active-low write enable. The user issues one request at a time: an address, a write flag and, for writes, a data byte. The controller turns that request into a fixed series of pin phases. Each phase lasts a whole number of clocks, and the clock counts are worked out from the RAM's minimum timing and the clock period.

All RAM pins come from registers. The bidirectional data bus appears as three signals: a driven value, a drive enable and a sampled input. The pad logic at the chip edge combines these into a tri-state pad. The controller turns the drive enable on only while the write enable is low. It releases the bus on the same clock edge that ends the write. Before any read that follows a write it inserts one idle clock, so the RAM and the controller never drive the bus together.

With the default 10 ns clock a read selects the RAM for 4 clocks. A write uses 1 address-setup clock followed by 3 clocks of write enable low. A one-clock `done` strobe marks the end of every operation.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, the RAM is deselected: mem_en_n=1, mem_en_p=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0. In this state done=0 and req_ready=1.
- R2: A read accepted at a clock edge holds the RAM selected with mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC clocks (4 by default). On the edge that ends those clocks the RAM is deselected.
- R3: rd_data takes the RAM data sampled on the last clock of the read access. It is valid in the done cycle and holds its value until the next read completes.
- R4: A write selects the RAM for one setup clock with mem_we_n=1. It then holds mem_we_n=0 for WP_CYC clocks (3 by default, which covers both the write pulse and the data setup). mem_oe_n stays 1 throughout the write.
- R5: mem_dq_oe is 1 exactly while mem_we_n is 0, with mem_dq_out equal to the request's data byte. WE rises, the bus is released and the RAM is deselected all on the same edge.
- R6: A read whose previous operation was a write starts with one extra idle turnaround clock. In that clock the RAM is deselected and req_ready=0.
- R7: done is 1 for exactly one clock after each completed operation, in the first deselected cycle.
- R8: req_ready is 1 only when the controller is idle. A req_valid pulse while busy is ignored: it changes no pin and starts no operation.
- R9: mem_addr holds the request's address, stable for the whole time the RAM is selected. The two enables always agree (mem_en_n is never equal to mem_en_p).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 8 | Last read result |
| done | output | 1 | One-clock completion strobe |
| mem_addr | output | 17 | RAM address pins |
| mem_en_n | output | 1 | Active-low chip enable |
| mem_en_p | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The first RAM pin change is due in the cycle right after the accepting edge. A read then completes 4 clocks later (5 after a write, because of the turnaround), and a write completes 1+3 clocks later. done and the new rd_data appear in the cycle that follows. The bench pushes the exact pin pattern for every clock of a request into a queue when it raises req_valid. At each falling clock edge it pops one entry and compares every output against it, so each result is checked in the one cycle it is due. A behavioural RAM on the pins stores data only at the end of the write strobe, and read-back against a separate shadow copy confirms what was actually written.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_READ,
        PH_WSETUP,
        PH_WPULSE
    } phase_e;

    typedef struct packed {
        logic en_n;
        logic en_p;
        logic oe_n;
        logic we_n;
        logic drv;
    } pins_t;

    localparam pins_t PINS_IDLE  = '{en_n: 1'b1, en_p: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    localparam pins_t PINS_READ  = '{en_n: 1'b0, en_p: 1'b1, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
    localparam pins_t PINS_WSET  = '{en_n: 1'b0, en_p: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    localparam pins_t PINS_WPUL  = '{en_n: 1'b0, en_p: 1'b1, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC = 4,
    parameter int unsigned WP_CYC = 3,
    parameter int unsigned CW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          take,
    output logic          capture,
    output pins_t         pins,
    output logic          done,
    output logic          ready
);
    typedef struct packed {
        phase_e phase;
        pins_t  pins;
        logic   done;
        logic   last_wr;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_IDLE, pins: PINS_IDLE, done: 1'b0, last_wr: 1'b0};
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WP_LOAD = CW'(WP_CYC - 1);

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take     = 1'b0;
        capture  = 1'b0;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    if (req_write) begin
                        nxt_d.phase = PH_WSETUP;
                        nxt_d.pins  = PINS_WSET;
                    end else if (cur_q.last_wr) begin
                        nxt_d.phase   = PH_TURN;
                        nxt_d.last_wr = 1'b0;
                    end else begin
                        nxt_d.phase = PH_READ;
                        nxt_d.pins  = PINS_READ;
                        tmr_load    = 1'b1;
                        tmr_val     = RD_LOAD;
                    end
                end
            end
            PH_TURN: begin
                nxt_d.phase = PH_READ;
                nxt_d.pins  = PINS_READ;
                tmr_load    = 1'b1;
                tmr_val     = RD_LOAD;
            end
            PH_READ: begin
                if (tmr_last) begin
                    capture     = 1'b1;
                    nxt_d.phase = PH_IDLE;
                    nxt_d.pins  = PINS_IDLE;
                    nxt_d.done  = 1'b1;
                end
            end
            PH_WSETUP: begin
                nxt_d.phase = PH_WPULSE;
                nxt_d.pins  = PINS_WPUL;
                tmr_load    = 1'b1;
                tmr_val     = WP_LOAD;
            end
            PH_WPULSE: begin
                if (tmr_last) begin
                    nxt_d.phase   = PH_IDLE;
                    nxt_d.pins    = PINS_IDLE;
                    nxt_d.done    = 1'b1;
                    nxt_d.last_wr = 1'b1;
                end
            end
            default: nxt_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SEQ_RST;
        else        cur_q <= nxt_d;
    end

    assign pins  = cur_q.pins;
    assign done  = cur_q.done;
    assign ready = (cur_q.phase == PH_IDLE);
endmodule

// File: rtl/sram_ctl_req_reg.sv
module sram_ctl_req_reg #(
    parameter int unsigned AW = 17,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] wdata_out,
    output logic [DW-1:0] rdata_out
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.addr  = addr_in;
            hold_d.wdata = data_in;
        end
        if (capture) begin
            hold_d.rdata = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign addr_out  = hold_q.addr;
    assign wdata_out = hold_q.wdata;
    assign rdata_out = hold_q.rdata;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW      = 17,
    parameter int unsigned DW      = 8,
    parameter int unsigned CLK_PS  = 10000,
    parameter int unsigned T_ACC_PS = 35000,
    parameter int unsigned T_OEA_PS = 10000,
    parameter int unsigned T_WEP_PS = 25000,
    parameter int unsigned T_DSU_PS = 20000,
    parameter int unsigned T_WCY_PS = 35000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_en_n,
    output logic          mem_en_p,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC = umax(umax(cdiv(T_ACC_PS, CLK_PS), cdiv(T_OEA_PS, CLK_PS)), 1);
    localparam int unsigned WP_CYC = umax(umax(cdiv(T_WEP_PS, CLK_PS), cdiv(T_DSU_PS, CLK_PS)),
                                          umax(cdiv(T_WCY_PS, CLK_PS), 2) - 1);
    localparam int unsigned MAXC   = umax(RD_CYC, WP_CYC);
    localparam int unsigned CW     = $clog2(MAXC + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          take;
    logic          capture;
    pins_t         pins;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_ctl_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .take      (take),
        .capture   (capture),
        .pins      (pins),
        .done      (done),
        .ready     (req_ready)
    );

    sram_ctl_req_reg #(.AW(AW), .DW(DW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .addr_in   (req_addr),
        .data_in   (req_wdata),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .addr_out  (mem_addr),
        .wdata_out (mem_dq_out),
        .rdata_out (rd_data)
    );

    assign mem_en_n  = pins.en_n;
    assign mem_en_p  = pins.en_p;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drv;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int unsigned AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_en_n,
    input logic          mem_en_p,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_en_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_read_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!mem_en_n && mem_we_n));

    assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_en_n));

    assert_drive_needs_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    assert_we_needs_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_release_with_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_en_n && !mem_dq_oe));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> mem_oe_n);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

    assert_enables_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_n != mem_en_p);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_en_n  (mem_en_n),
    .mem_en_p  (mem_en_p),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rd_data;
    logic        done;
    logic [16:0] mem_addr;
    logic        mem_en_n, mem_en_p, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit fin    = 1'b0;

    always #5 clk = ~clk;

    sram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .done(done), .mem_addr(mem_addr), .mem_en_n(mem_en_n),
        .mem_en_p(mem_en_p), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // behavioural RAM: stores at the end of the write strobe
    byte unsigned ram [int];
    bit           pend = 1'b0;
    logic [16:0]  pend_a;
    logic [7:0]   pend_d;

    function automatic logic [7:0] init_val(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] ram_rd(input logic [16:0] a);
        if (ram.exists(int'(a))) return ram[int'(a)];
        return init_val(a);
    endfunction

    always @(negedge clk) begin
        if (!mem_en_n && mem_en_p && !mem_we_n) begin
            pend   = 1'b1;
            pend_a = mem_addr;
            pend_d = mem_dq_oe ? mem_dq_out : 8'hxx;
        end else if (pend) begin
            ram[int'(pend_a)] = pend_d;
            pend = 1'b0;
        end
        if (!mem_en_n && mem_en_p && !mem_oe_n && mem_we_n)
            mem_dq_in <= ram_rd(mem_addr);
        else
            mem_dq_in <= 8'hEE;
    end

    // expected-cycle queue
    typedef struct {
        bit          sel;
        bit          oe_n;
        bit          we_n;
        bit          drv;
        logic [16:0] a;
        logic [7:0]  d;
        bit          dn;
        bit          rdy;
        bit          rdv;
        logic [7:0]  rd;
        string       tag;
    } exp_t;

    exp_t        exp_q [$];
    logic [7:0]  shadow [int];
    bit          prev_wr = 1'b0;
    bit          have_rd = 1'b0;
    logic [7:0]  hold_rd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, expv);
        end
    endtask

    function automatic exp_t idle_e(input bit dn, input bit rdy, input string tag);
        exp_t e;
        e.sel = 0; e.oe_n = 1; e.we_n = 1; e.drv = 0; e.a = '0; e.d = '0;
        e.dn = dn; e.rdy = rdy; e.rdv = 0; e.rd = '0; e.tag = tag;
        return e;
    endfunction

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !fin) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_e(0, 1, "R1");
            chk(mem_en_n == !e.sel && mem_en_p == e.sel, e.tag, {mem_en_n, mem_en_p}, {!e.sel, e.sel});
            chk(req_ready == e.rdy, (e.tag == "R6") ? "R6" : "R8", req_ready, e.rdy);
            chk(mem_oe_n == e.oe_n, (e.tag == "R4") ? "R4" : "R2", mem_oe_n, e.oe_n);
            chk(mem_we_n == e.we_n, "R4", mem_we_n, e.we_n);
            chk(mem_dq_oe == e.drv, "R5", mem_dq_oe, e.drv);
            if (e.drv) chk(mem_dq_out == e.d, "R5", mem_dq_out, e.d);
            if (e.sel) chk(mem_addr == e.a, "R9", mem_addr, e.a);
            chk(done == e.dn, "R7", done, e.dn);
            if (e.rdv) begin
                have_rd = 1'b1;
                hold_rd = e.rd;
            end
            if (have_rd) chk(rd_data === hold_rd, "R3", rd_data, hold_rd);
        end
    end

    task automatic wait_free();
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() == 0) break;
        end
    endtask

    task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d,
                          input bit poke, input logic [16:0] pa);
        exp_t e;
        wait_free();
        if (wr) begin
            e = idle_e(0, 0, "R4"); e.sel = 1; e.a = a;
            exp_q.push_back(e);
            for (int i = 0; i < 3; i++) begin
                e = idle_e(0, 0, "R4"); e.sel = 1; e.a = a; e.we_n = 0; e.drv = 1; e.d = d;
                exp_q.push_back(e);
            end
            exp_q.push_back(idle_e(1, 1, "R7"));
            shadow[int'(a)] = d;
        end else begin
            if (prev_wr) exp_q.push_back(idle_e(0, 0, "R6"));
            for (int i = 0; i < 4; i++) begin
                e = idle_e(0, 0, "R2"); e.sel = 1; e.a = a; e.oe_n = 0;
                exp_q.push_back(e);
            end
            e = idle_e(1, 1, "R3"); e.rdv = 1;
            e.rd = shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
            exp_q.push_back(e);
        end
        prev_wr   = wr;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk); #1;
            req_valid = 1'b1; req_write = !wr; req_addr = pa; req_wdata = 8'h99;
            @(negedge clk); #1;
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_en_n && !mem_en_p && mem_oe_n && mem_we_n && !mem_dq_oe, "R1",
            {mem_en_n, mem_en_p, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        chk(!done && req_ready, "R1", {done, req_ready}, 2'b01);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_req(1, 17'h00000, 8'h3C, 0, '0);
        do_req(1, 17'h1FFFF, 8'hA5, 0, '0);
        do_req(0, 17'h1FFFF, 8'h00, 0, '0);     // R6 turnaround
        do_req(0, 17'h00000, 8'h00, 0, '0);     // back-to-back reads
        do_req(0, 17'h12345, 8'h00, 0, '0);     // unwritten location
        do_req(1, 17'h0AAAA, 8'hFF, 1, 17'h00055); // R8 poke while busy
        do_req(0, 17'h0AAAA, 8'h00, 1, 17'h00077); // R8 poke while reading
        do_req(1, 17'h15555, 8'h00, 0, '0);
        do_req(1, 17'h15556, 8'h81, 0, '0);
        repeat (4) @(negedge clk);              // idle gap, R3 hold
        do_req(0, 17'h15555, 8'h00, 0, '0);     // turnaround after a gap
        do_req(0, 17'h15556, 8'h00, 0, '0);
        do_req(0, 17'h00055, 8'h00, 0, '0);     // poked address must be untouched
        wait_free();
        repeat (3) @(negedge clk);
        fin = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule